// File: doc/BRIEF.md
# Status Word Write Filter

This block holds a 32-bit processor status word and applies a move-to-status write to it. Each bit belongs to one of three protection classes. Open bits can be written from any mode. Side-state bits are never touched by the move. Guarded bits can be written by the move only when the current mode is privileged. A 4-bit lane mask picks which bytes of the move data take part in the write.

Three side-effect ports also update the word. The first writes the four condition flags from an execution result. The second writes the two instruction-state bits. The third performs exception entry, which loads the interrupt masks and the mode field in any mode. When several sources act in the same cycle, fixed rules decide the result, and a move that would load an undefined mode encoding is partly refused and flagged.

Top module: `status_word_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, status reads 32'h0000_01D3. That value has A, I and F at 1 and the mode set to 5'b10011. illegal_mode reads 0.
- R2: The open bits can be written by a move in every mode, including user mode 5'b10000. These are N, Z, C, V, Q (bits 31..27), GE (bits 19..16) and E (bit 9).
- R3: Lane mask bit k enables status bits [8k+7:8k]. A bit in a disabled lane keeps its value.
- R4: The side-state bits J (bit 24) and T (bit 5) ignore move data. They change only when st_we loads st_j and st_t.
- R5: In user mode (status[4:0] == 5'b10000), a move does not change the guarded bits. These are A (bit 8), I (bit 7), F (bit 6) and M (bits 4..0).
- R6: In any mode other than 5'b10000, a move writes the guarded bits in enabled lanes.
- R7: exc_we loads exc_aif into bits 8..6 (A, I, F) and exc_mode into bits 4..0, in any mode including user mode. exc_mode is always a legal encoding.
- R8: When exc_we and mv_we are high in the same cycle, the whole move is discarded.
- R9: The legal mode encodings are 10000, 10001, 10010, 10011, 10110, 10111, 11011 and 11111. A move may write an encoding outside this set into bits 4..0 of an enabled lane 0 in a privileged mode. In that case M keeps its value and illegal_mode is high for exactly the next cycle. The other bits of the move are still applied.
- R10: Every bit not named in R2, R4 or R5 always reads 0.
- R11: flg_we loads flg_nzcv into bits 31..28. It takes priority over a move in the same cycle.
- R12: The mode output always equals status[4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mv_we | input | 1 | Move-to-status write strobe |
| mv_lanes | input | 4 | Byte lane enables for the move |
| mv_data | input | 32 | Move write data |
| flg_we | input | 1 | Condition flag update strobe |
| flg_nzcv | input | 4 | New N, Z, C, V flags |
| st_we | input | 1 | Side-state update strobe |
| st_j | input | 1 | New J bit |
| st_t | input | 1 | New T bit |
| exc_we | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode entered on exception |
| exc_aif | input | 3 | New A, I, F masks on exception |
| status | output | 32 | Current status word |
| mode | output | 5 | Current mode field |
| illegal_mode | output | 1 | Pulse after a refused mode write |

## Verification
The assertions check the following on every cycle:
- the reserved bits stay zero;
- the side-state bits hold without their strobe;
- the guarded bits hold in user mode;
- exception entry loads its fields and blocks the move;
- the flag port wins over the move;
- the mode field never leaves the legal set and holds while illegal_mode is raised.

Only the bench's sweeps can show the full per-bit outcome of a move. That outcome depends on the lane mask, the privilege level and the data pattern together, across every legal mode and all sixteen lane masks. The bench also covers the one-cycle width of the illegal-mode pulse and the reset value.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int SW_W   = 32;
  localparam int MODE_W = 5;
  localparam int LANES  = SW_W / 8;

  localparam logic [SW_W-1:0] CLS_OPEN = 32'hF80F_0200;
  localparam logic [SW_W-1:0] CLS_PRIV = 32'h0000_01DF;
  localparam logic [SW_W-1:0] CLS_SIDE = 32'h0100_0020;
  localparam logic [SW_W-1:0] M_FIELD  = 32'h0000_001F;

  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
  localparam logic [SW_W-1:0]   RESET_WORD = 32'h0000_01D3;

  localparam int POS_J = 24;
  localparam int POS_T = 5;
  localparam int POS_FLAGS_LO = 28;
  localparam int POS_AIF_LO = 6;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      5'b10000, 5'b10001, 5'b10010, 5'b10011,
      5'b10110, 5'b10111, 5'b11011, 5'b11111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [SW_W-1:0] lane_expand(input logic [LANES-1:0] l);
    logic [SW_W-1:0] r;
    for (int i = 0; i < SW_W; i++) r[i] = l[i/8];
    return r;
  endfunction
endpackage

// File: rtl/stw_lane_mask.sv
module stw_lane_mask
  import stw_pkg::*;
(
  input  logic [LANES-1:0] lanes,
  input  logic             priv,
  output logic [SW_W-1:0]  wmask
);
  logic [SW_W-1:0] class_ok;

  always_comb begin
    class_ok = CLS_OPEN | (priv ? CLS_PRIV : '0);
    wmask    = lane_expand(lanes) & class_ok;
  end
endmodule

// File: rtl/stw_mode_check.sv
module stw_mode_check
  import stw_pkg::*;
(
  input  logic [MODE_W-1:0] cand,
  output logic              legal
);
  always_comb legal = mode_legal(cand);
endmodule

// File: rtl/status_word_ctrl.sv
module status_word_ctrl
  import stw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mv_we,
  input  logic [3:0]  mv_lanes,
  input  logic [31:0] mv_data,
  input  logic        flg_we,
  input  logic [3:0]  flg_nzcv,
  input  logic        st_we,
  input  logic        st_j,
  input  logic        st_t,
  input  logic        exc_we,
  input  logic [4:0]  exc_mode,
  input  logic [2:0]  exc_aif,
  output logic [31:0] status,
  output logic [4:0]  mode,
  output logic        illegal_mode
);
  logic            priv;
  logic [SW_W-1:0] wmask;
  logic            cand_legal;
  logic            mv_go;
  logic            mode_touch;
  logic            mode_bad;
  logic [SW_W-1:0] eff_mask;
  logic [SW_W-1:0] nxt;

  assign priv = (status[MODE_W-1:0] != MODE_USER);

  stw_lane_mask u_mask (
    .lanes (mv_lanes),
    .priv  (priv),
    .wmask (wmask)
  );

  stw_mode_check u_mchk (
    .cand  (mv_data[MODE_W-1:0]),
    .legal (cand_legal)
  );

  assign mv_go      = mv_we & ~exc_we;
  assign mode_touch = mv_go & (|(wmask & M_FIELD));
  assign mode_bad   = mode_touch & ~cand_legal;

  always_comb begin
    eff_mask = mv_go ? wmask : '0;
    if (mode_bad) eff_mask = eff_mask & ~M_FIELD;
    nxt = (status & ~eff_mask) | (mv_data & eff_mask);
    if (flg_we) nxt[SW_W-1:POS_FLAGS_LO] = flg_nzcv;
    if (st_we) begin
      nxt[POS_J] = st_j;
      nxt[POS_T] = st_t;
    end
    if (exc_we) begin
      nxt[POS_AIF_LO+2:POS_AIF_LO] = exc_aif;
      nxt[MODE_W-1:0] = exc_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status       <= RESET_WORD;
      illegal_mode <= 1'b0;
    end else begin
      status       <= nxt;
      illegal_mode <= mode_bad;
    end
  end

  assign mode = status[MODE_W-1:0];
endmodule

// File: rtl/stw_checker.sv
module stw_checker
  import stw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        exc_we,
  input logic [4:0]  exc_mode,
  input logic [2:0]  exc_aif,
  input logic        st_we,
  input logic        flg_we,
  input logic [3:0]  flg_nzcv,
  input logic [31:0] status,
  input logic [4:0]  mode,
  input logic        illegal_mode,
  input logic        mv_go
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~(CLS_OPEN | CLS_PRIV | CLS_SIDE)) == '0); // R10

  AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !st_we |=> (status[POS_J] == $past(status[POS_J])) && (status[POS_T] == $past(status[POS_T]))); // R4

  AST_USER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_USER && !exc_we) |=> ((status & CLS_PRIV) == ($past(status) & CLS_PRIV))); // R5

  AST_EXC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_we |=> (status[4:0] == $past(exc_mode)) && (status[8:6] == $past(exc_aif))); // R7

  AST_EXC_BLOCKS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_we |-> !mv_go); // R8

  AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> (status[4:0] == $past(status[4:0]))); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(mode)); // R9

  AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we |=> (status[31:28] == $past(flg_nzcv))); // R11
endmodule

bind status_word_ctrl stw_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_we       (exc_we),
  .exc_mode     (exc_mode),
  .exc_aif      (exc_aif),
  .st_we        (st_we),
  .flg_we       (flg_we),
  .flg_nzcv     (flg_nzcv),
  .status       (status),
  .mode         (mode),
  .illegal_mode (illegal_mode),
  .mv_go        (mv_go)
);

// File: tb/status_word_ctrl_bench.sv
module status_word_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mv_we;
  logic [3:0]  mv_lanes;
  logic [31:0] mv_data;
  logic        flg_we;
  logic [3:0]  flg_nzcv;
  logic        st_we, st_j, st_t;
  logic        exc_we;
  logic [4:0]  exc_mode;
  logic [2:0]  exc_aif;
  logic [31:0] status;
  logic [4:0]  mode;
  logic        illegal_mode;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_w;
  logic        exp_ill;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_word_ctrl u_status_word_ctrl (
    .clk(clk), .rst_n(rst_n), .mv_we(mv_we), .mv_lanes(mv_lanes), .mv_data(mv_data),
    .flg_we(flg_we), .flg_nzcv(flg_nzcv), .st_we(st_we), .st_j(st_j), .st_t(st_t),
    .exc_we(exc_we), .exc_mode(exc_mode), .exc_aif(exc_aif),
    .status(status), .mode(mode), .illegal_mode(illegal_mode)
  );

  function automatic bit b_legal(input logic [4:0] m);
    logic [31:0] set = 32'h0;
    set[16] = 1; set[17] = 1; set[18] = 1; set[19] = 1;
    set[22] = 1; set[23] = 1; set[27] = 1; set[31] = 1;
    return set[m];
  endfunction

  function automatic logic [4:0] mode_at(input int i);
    case (i)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010; 3: return 5'b10011;
      4: return 5'b10110; 5: return 5'b10111; 6: return 5'b11011; default: return 5'b11111;
    endcase
  endfunction

  function automatic logic [32:0] b_move(input logic [31:0] cur, input logic [31:0] d,
                                         input logic [3:0] ln);
    logic [31:0] w = cur;
    logic ill = 0;
    bit user = (cur[4:0] == 5'b10000);
    for (int i = 0; i < 32; i++) begin
      bit open = (i >= 27) || (i >= 16 && i <= 19) || (i == 9);
      bit grd  = (i >= 6 && i <= 8) || (i <= 4);
      if (ln[i >> 3] && (open || (grd && !user))) w[i] = d[i];
    end
    if (ln[0] && !user && !b_legal(d[4:0])) begin
      w[4:0] = cur[4:0];
      ill = 1;
    end
    return {ill, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mv_we = 0; mv_lanes = 0; mv_data = 0; flg_we = 0; flg_nzcv = 0;
    st_we = 0; st_j = 0; st_t = 0; exc_we = 0; exc_mode = 5'b10011; exc_aif = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    step(); step();
    check("R1 reset word", status, 32'h0000_01D3);
    check("R1 reset illegal", {31'b0, illegal_mode}, 32'b0);
    rst_n = 1;
    step();
    check("R1 word after release", status, 32'h0000_01D3);
    check("R12 mode out", {27'b0, mode}, 32'h13);
    exp_w = 32'h0000_01D3;

    for (int mi = 0; mi < 8; mi++) begin
      for (int ln = 0; ln < 16; ln++) begin
        for (int dp = 0; dp < 4; dp++) begin
          logic [31:0] d;
          logic [32:0] r;
          case (dp)
            0: d = 32'hFFFF_FFFF;
            1: d = 32'h0000_0000;
            2: d = 32'hA5A5_A5A5;
            default: d = 32'h5A5A_5A52;
          endcase
          exc_we = 1; exc_mode = mode_at(mi); exc_aif = ln[2:0] ^ dp[2:0];
          step();
          exc_we = 0;
          exp_w[8:6] = ln[2:0] ^ dp[2:0];
          exp_w[4:0] = mode_at(mi);
          check("R7 exception entry", status, exp_w);
          mv_we = 1; mv_data = d; mv_lanes = ln[3:0];
          step();
          mv_we = 0;
          r = b_move(exp_w, d, ln[3:0]);
          exp_w = r[31:0];
          exp_ill = r[32];
          check("R2/R3/R4/R5/R6/R10 move result", status, exp_w);
          check("R9 illegal pulse", {31'b0, illegal_mode}, {31'b0, exp_ill});
          step();
          check("R9 pulse ends", {31'b0, illegal_mode}, 32'b0);
          check("R12 mode out", {27'b0, mode}, {27'b0, exp_w[4:0]});
        end
      end
    end

    // R4: side-state port sets J and T; a move of zeros leaves them
    exc_we = 1; exc_mode = 5'b11111; exc_aif = 3'b000;
    step();
    exc_we = 0;
    exp_w[8:6] = 0; exp_w[4:0] = 5'b11111;
    st_we = 1; st_j = 1; st_t = 1;
    step();
    st_we = 0;
    exp_w[24] = 1; exp_w[5] = 1;
    check("R4 side port load", status, exp_w);
    mv_we = 1; mv_lanes = 4'hF; mv_data = 32'h0000_0010;
    step();
    mv_we = 0;
    exp_w = b_move(exp_w, 32'h0000_0010, 4'hF);
    check("R4 side bits kept on move", status, exp_w);
    check("R4 J/T still set", {30'b0, status[24], status[5]}, 32'h3);

    // R11: flag port beats a move of ones on the flag bits, user mode
    mv_we = 1; mv_lanes = 4'hF; mv_data = 32'hFFFF_FFFF; flg_we = 1; flg_nzcv = 4'b0101;
    step();
    mv_we = 0; flg_we = 0;
    exp_w = b_move(exp_w, 32'hFFFF_FFFF, 4'hF);
    exp_w[31:28] = 4'b0101;
    check("R11 flag priority", status, exp_w);

    // R8: exception and move together -> move dropped
    mv_we = 1; mv_lanes = 4'hF; mv_data = 32'h0000_0000;
    exc_we = 1; exc_mode = 5'b10010; exc_aif = 3'b111;
    step();
    mv_we = 0; exc_we = 0;
    exp_w[8:6] = 3'b111; exp_w[4:0] = 5'b10010;
    check("R8 move discarded", status, exp_w);
    check("R8 no illegal pulse", {31'b0, illegal_mode}, 32'b0);

    // R10: reserved bits zero after an all-ones privileged write
    mv_we = 1; mv_lanes = 4'hF; mv_data = 32'hFFFF_FFFF;
    step();
    mv_we = 0;
    check("R10 reserved zero", status & ~32'hF90F_03FF, 32'h0);

    done = 1;
    summary();
  end
endmodule